// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block is the transmit half of a controller-side AC-link port. It runs directly on the 12.288 MHz serial bit clock. Each output frame lasts 256 bit times, which gives a 48 kHz frame rate. The block drives the frame marker and the serial data line.

Every frame starts with a 16-bit tag word. The tag word is followed by twelve 20-bit slots. Upstream logic holds five payload words on parallel inputs: command address, command data, left sample, right sample and modem word. It also holds one valid flag per payload word. The block takes a snapshot of these inputs once per frame and builds the tag word from the flags. Any slot that is not tagged is filled with zeros. The result is then shifted out one bit per clock.

A one-cycle strobe marks the last bit time of each frame, so the upstream logic knows when to present the next set of inputs.

Top module: `aclink_tx_frame`

## Requirements
- R1: A frame lasts exactly 256 bit times. `frame_done` is high during the last bit time of each frame and low at every other time.
- R2: `sync` is high during the first 16 bit times of every frame (the tag word) and low for the other 240.
- R3: Tag bits are sent first-to-last in this order: a frame-valid bit, then the flags for slots 1 to 5 in slot order, then ten zeros. The frame-valid bit is the OR of the five `slot_valid` bits. `slot_valid[k]` flags slot k+1.
- R4: A slot whose flag is 0 is driven low for all 20 of its bit times.
- R5: A tagged slot carries its payload as follows: slot 1 `cmd_addr`, slot 2 `cmd_data`, slot 3 `pcm_left`, slot 4 `pcm_right`, slot 5 `modem_data`.
- R6: The tag word is sent before the slots, and the slots go out in order 1 to 12. Each field is sent most significant bit first.
- R7: Payloads and flags are captured at the rising edge that ends the `frame_done` bit time. Input changes at any other time do not affect the frame being sent.
- R8: While `rst_n` is low, `sync`, `sdata` and `frame_done` are low. The first frame starts at the first rising edge after reset is released.
- R9: Slots 6 to 12 are driven low for every bit time of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock. Outputs change on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_addr | input | 20 | Payload for slot 1 |
| cmd_data | input | 20 | Payload for slot 2 |
| pcm_left | input | 20 | Payload for slot 3 |
| pcm_right | input | 20 | Payload for slot 4 |
| modem_data | input | 20 | Payload for slot 5 |
| slot_valid | input | 5 | Valid flags for slots 1 to 5 (bit 0 is slot 1) |
| sync | output | 1 | Frame marker, high during the tag word |
| sdata | output | 1 | Serial frame data |
| frame_done | output | 1 | Strobe during the last bit time of a frame |

## Verification
The assertions assume a synchronous reset and known values on `slot_valid` and the payload inputs at every rising edge. They also assume the inputs never change at a rising edge itself, so that the captured value is the one present during the `frame_done` bit time. The bench drives every input on falling edges, which is also when it samples `sdata`, `sync` and `frame_done`. It loads the next frame's inputs in the `frame_done` bit time. In some frames it also rewrites all inputs with junk in the middle of the frame, so the R7 snapshot is exercised.

// File: rtl/aclink_pkg.sv
// Package: shared frame geometry for the AC-link transmitter.
// Assumes a 16-bit tag slot followed by equal-width data slots.
package aclink_pkg;
    localparam int TAG_W   = 16;
    localparam int SLOT_W  = 20;
    localparam int N_SLOTS = 12;
    localparam int N_PAY   = 5;
    localparam int FRAME_W = TAG_W + SLOT_W * N_SLOTS;
endpackage

// File: rtl/aclink_frame_builder.sv
// Module: aclink_frame_builder
// Combinational assembly of one whole frame image, tag word first, MSB first.
// Assumes N_PAY < TAG_W so that every payload slot has a tag bit.
module aclink_frame_builder #(
    parameter int TAG_W   = aclink_pkg::TAG_W,
    parameter int SLOT_W  = aclink_pkg::SLOT_W,
    parameter int N_SLOTS = aclink_pkg::N_SLOTS,
    parameter int N_PAY   = aclink_pkg::N_PAY,
    localparam int FRAME_W = TAG_W + SLOT_W * N_SLOTS
) (
    input  logic [N_PAY*SLOT_W-1:0] payload,
    input  logic [N_PAY-1:0]        slot_vld,
    output logic [FRAME_W-1:0]      frame
);
    logic [TAG_W-1:0] tag;

    // Tag word: frame-valid bit on top, then one flag per payload slot.
    always_comb begin
        tag            = '0;
        tag[TAG_W-1]   = |slot_vld;
        for (int k = 0; k < N_PAY; k++) begin
            tag[TAG_W-2-k] = slot_vld[k];
        end
    end

    assign frame[FRAME_W-1 -: TAG_W] = tag;

    // Data slots: payload when flagged, zero-stuffed otherwise or when reserved.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        if (s < N_PAY) begin : g_pay
            assign frame[FRAME_W-TAG_W-1-s*SLOT_W -: SLOT_W] =
                slot_vld[s] ? payload[s*SLOT_W +: SLOT_W] : '0;
        end else begin : g_rsvd
            assign frame[FRAME_W-TAG_W-1-s*SLOT_W -: SLOT_W] = '0;
        end
    end
endmodule

// File: rtl/aclink_bit_counter.sv
// Module: aclink_bit_counter
// Tracks the bit position within the frame and derives the load request,
// the frame marker and the end-of-frame strobe.
// Assumes one clock per bit time. Idle after reset until the first edge.
module aclink_bit_counter #(
    parameter int TAG_W   = aclink_pkg::TAG_W,
    parameter int FRAME_W = aclink_pkg::FRAME_W,
    localparam int POS_W  = $clog2(FRAME_W)
) (
    input  logic clk,
    input  logic rst_n,
    output logic load,
    output logic run,
    output logic sync,
    output logic frame_done
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] TAG_END  = POS_W'(TAG_W);

    logic [POS_W-1:0] pos_q;
    logic             run_q;

    // A load is needed when idle or on the last bit of the current frame.
    assign load       = !run_q || (pos_q == LAST_POS);
    assign run        = run_q;
    assign frame_done = run_q && (pos_q == LAST_POS);
    assign sync       = run_q && (pos_q < TAG_END);

    // Position counter: restarts at zero on each frame load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pos_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // R1: the strobe never lasts two cycles
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R1: a new frame starts right after the strobe
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (pos_q == '0) && sync);
    // R2: the marker rises only at a frame start
    p_sync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> ($past(frame_done) || !$past(run_q)));
endmodule

// File: rtl/aclink_shifter.sv
// Module: aclink_shifter
// Frame-wide parallel-load shift register, MSB out first.
// Assumes load is asserted once per frame. Clears to zero in reset.
module aclink_shifter #(
    parameter int FRAME_W = aclink_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               bit_out
);
    logic [FRAME_W-1:0] shreg_q;

    // Capture the frame image on load, otherwise shift one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= frame_in;
        end else begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign bit_out = shreg_q[FRAME_W-1];

    // R7: the register holds exactly the image present at the load edge
    p_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> shreg_q == $past(frame_in));
endmodule

// File: rtl/aclink_tx_frame.sv
// Module: aclink_tx_frame (top)
// Controller-side AC-link output frame serializer on the bit clock.
// Assumes payload and flag inputs are stable at each rising edge. They are
// captured at the edge that closes the frame_done bit time.
module aclink_tx_frame #(
    parameter int SLOT_W = aclink_pkg::SLOT_W,
    parameter int N_PAY  = aclink_pkg::N_PAY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cmd_addr,
    input  logic [SLOT_W-1:0] cmd_data,
    input  logic [SLOT_W-1:0] pcm_left,
    input  logic [SLOT_W-1:0] pcm_right,
    input  logic [SLOT_W-1:0] modem_data,
    input  logic [N_PAY-1:0]  slot_valid,
    output logic              sync,
    output logic              sdata,
    output logic              frame_done
);
    localparam int TAG_W   = aclink_pkg::TAG_W;
    localparam int N_SLOTS = aclink_pkg::N_SLOTS;
    localparam int FRAME_W = TAG_W + SLOT_W * N_SLOTS;

    logic [N_PAY*SLOT_W-1:0] payload;
    logic [FRAME_W-1:0]      frame_img;
    logic                    load;
    logic                    run;

    // Payload vector in slot order, slot 1 in the lowest lane.
    assign payload = {modem_data, pcm_right, pcm_left, cmd_data, cmd_addr};

    aclink_frame_builder #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .N_PAY(N_PAY)
    ) u_build (
        .payload (payload),
        .slot_vld(slot_valid),
        .frame   (frame_img)
    );

    aclink_bit_counter #(.TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (run),
        .sync      (sync),
        .frame_done(frame_done)
    );

    aclink_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .frame_in(frame_img),
        .bit_out (sdata)
    );

    // R3: first bit of each frame is the OR of the flags captured
    p_valid_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> sdata == $past(|slot_valid));
    // R8: before the first frame the line is idle
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sdata && !sync && !frame_done);
endmodule

// File: tb/sim_aclink_tx_frame.sv
`timescale 1ns/1ps
module sim_aclink_tx_frame;
    localparam int N_FRAMES = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] a, d, l, r, m;
    logic [4:0]  v;
    wire         sync, sdata, fd;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    aclink_tx_frame u0 (
        .clk(clk), .rst_n(rst_n), .cmd_addr(a), .cmd_data(d),
        .pcm_left(l), .pcm_right(r), .modem_data(m), .slot_valid(v),
        .sync(sync), .sdata(sdata), .frame_done(fd)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected frame image per R3, R4, R5, R6, R9
    function automatic logic [255:0] build(input logic [19:0] pa, pd, pl, pr, pm,
                                           input logic [4:0] pv);
        logic [255:0] f;
        logic [19:0]  p [5];
        p[0] = pa; p[1] = pd; p[2] = pl; p[3] = pr; p[4] = pm;
        f = '0;
        f[255] = |pv;
        for (int k = 0; k < 5; k++) begin
            f[254-k] = pv[k];
            if (pv[k]) f[239-20*k -: 20] = p[k];
        end
        return f;
    endfunction

    function automatic string bit_tag(input int i, input logic [4:0] pv);
        int k;
        if (i < 16) return "R3 R6 tag bit";
        k = (i - 16) / 20;
        if (k >= 5) return "R9 reserved slot";
        if (!pv[k]) return "R4 zero stuffing";
        return "R5 R6 slot payload";
    endfunction

    task automatic pick(input int idx);
        case (idx)
            0: begin a = '1; d = '1; l = '1; r = '1; m = '1; v = 5'b00000; end
            1: begin a = 20'h80001; d = 20'h5A5A5; l = 20'hFFFFF; r = 20'h12345;
                     m = 20'hC0003; v = 5'b11111; end
            2: begin a = '1; d = '1; l = 20'hA5A5A; r = '1; m = '1; v = 5'b00100; end
            3: begin a = 20'h0; d = 20'h0; l = 20'h0; r = 20'h0; m = 20'hFFFFF;
                     v = 5'b10000; end
            default: begin
                a = 20'($urandom); d = 20'($urandom); l = 20'($urandom);
                r = 20'($urandom); m = 20'($urandom); v = 5'($urandom);
            end
        endcase
    endtask

    initial begin
        logic [255:0] exp_f;
        logic [255:0] got_f;
        logic [4:0]   cur_v;
        void'($urandom(32'd20240611));
        pick(0);
        // R8: outputs idle in reset
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!sync && !sdata && !fd, "R8 reset idle", {sync, sdata, fd}, 3'b000);
        end
        exp_f = build(a, d, l, r, m, v);
        cur_v = v;
        rst_n = 1'b1;
        for (int f = 0; f < N_FRAMES; f++) begin
            got_f = '0;
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                got_f[255-i] = sdata;
                chk(sdata === exp_f[255-i], bit_tag(i, cur_v), sdata, exp_f[255-i]);
                chk(sync === (i < 16), "R2 sync window", sync, (i < 16));
                chk(fd === (i == 255), "R1 frame_done strobe", fd, (i == 255));
                // R7: junk on all inputs mid-frame must not reach the current frame
                if ((f % 2 == 1) && (i == 100 || i == 200)) pick(99);
                if (i == 255) begin
                    pick(f + 1);
                    cur_v = v;
                end
            end
            chk(got_f === exp_f, "R7 frame snapshot", got_f, exp_f);
            exp_f = build(a, d, l, r, m, v);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule